// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits between a processor's write path and a flash program/erase engine. It watches each bus write aimed at the flash array and decides whether that write is part of a legal multi-write command. Commands are guarded by a two-write key handshake made at two configurable word indices. Once a sequence completes, the block issues a one-cycle request to the engine: program one word, erase the whole chip, erase one sector, or abandon the current operation.

The sequencer also reports its position in the command (its cycle code), the latched mode code and whether the key-skip shortcut ("bypass") is armed. The read path uses the mode code to pick array data, identification data, status or query data. A done pulse from the engine closes an erase and returns the sequencer to the command-ready position that fits the bypass flag. Write strobes are plain single-cycle pulses. Every write is consumed in the cycle it arrives and there is no back-pressure. The engine side carries no ready either: it must take each request pulse in the cycle it appears.

Top module: `flash_unlock_seq`

## Requirements
- R1: After a synchronous active-low reset, seq_cycle is 0, mode_code is 0x00, bypass_on is 0 and all request pulses are 0.
- R2: A write whose low data byte is 0xF0 returns the sequencer to cycle 0, mode 0x00 and bypass cleared, and pulses reset_req. This applies in every state except while mode_code is 0xA0 (program armed).
- R3: In cycle 0 a write of 0xAA at index UNLOCK0 moves to cycle 1. In cycle 1 a write of 0x55 at index UNLOCK1 moves to cycle 2. Any other write in these cycles resets to cycle 0 with mode 0x00 and bypass cleared. The index is the low IDX_W bits of wr_addr.
- R4: In cycle 2 without bypass, the write index must equal UNLOCK0. A data byte of 0x80, 0x90 or 0xA0 then becomes mode_code and the sequencer moves to cycle 3. Any other byte, or a wrong index, resets.
- R5: With mode 0xA0 in cycle 3, the next write raises prog_req for exactly the following cycle, carrying that write's address, data and size. Without bypass the sequencer then resets to cycle 0.
- R6: In cycle 2, data 0x20 sets bypass_on and stays in cycle 2 with mode 0x00. While bypass is on, cycle 2 accepts commands at any index, and a completed program returns to cycle 2 with mode 0x00 and bypass kept.
- R7: With mode 0x80, cycles 3 and 4 must repeat the key pair (0xAA at UNLOCK0, then 0x55 at UNLOCK1). In cycle 5, 0x10 at UNLOCK0 pulses chip_erase_req. A 0x30 at any index pulses sector_erase_req, with req_addr equal to the write address with its low log2(SECTOR_WORDS) bits cleared. Either one sets mode to that byte and seq_cycle to 6. Anything else resets.
- R8: In cycle 6 (erase running) every write other than 0xF0 is ignored: cycle, mode and bypass hold and no request is raised.
- R9: A write of 0x98 at index QUERY_IDX in cycle 0, or in cycle 3 with mode 0x90, enters query state: seq_cycle 7, mode 0x98. Any write in query state resets to cycle 0.
- R10: In cycle 3 with mode 0x90 (identification), a data byte of 0x00 with bypass on resets. Any write that is neither that nor a query entry also resets.
- R11: An eng_done pulse sets mode 0x00 and moves to cycle 2 if bypass is on, otherwise to cycle 0. A write in the same cycle is dropped.
- R12: At most one of prog_req, chip_erase_req, sector_erase_req and reset_req is high in any cycle, and each is high for one cycle per triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; commands use the low byte |
| wr_size | input | 2 | Access size code, passed through to program requests |
| eng_done | input | 1 | Engine finished the running erase |
| mode_code | output | 8 | Latched command byte for the read path |
| seq_cycle | output | 3 | Write-cycle position (0..6, 7 = query) |
| bypass_on | output | 1 | Key-skip shortcut armed |
| prog_req | output | 1 | Program one word |
| chip_erase_req | output | 1 | Erase whole array |
| sector_erase_req | output | 1 | Erase the sector at req_addr |
| reset_req | output | 1 | Abort request to the engine |
| req_addr | output | ADDR_W | Address for program or sector erase |
| req_data | output | DATA_W | Program data |
| req_size | output | 2 | Program size code |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=16, IDX_W=11, key indices 0x555 and 0x2AA, query index 0x55 and SECTOR_WORDS=256. The small sector makes the alignment of a sector-erase address visible on a short, arbitrary address such as 0x1234, whose expected aligned value is 0x1200. The narrow address means an index that matches in the low 11 bits but not above them exercises the partial-index compare. The distinct key indices let a key written at the wrong one be told apart from a correct sequence.

// File: rtl/fus_pkg.sv
package fus_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_KEY2    = 3'd1,
    CYC_CMD     = 3'd2,
    CYC_ARG     = 3'd3,
    CYC_ER_KEY2 = 3'd4,
    CYC_ER_SEL  = 3'd5,
    CYC_ERASING = 3'd6,
    CYC_QUERY   = 3'd7
  } cyc_e;

  localparam logic [7:0] OP_NONE    = 8'h00;
  localparam logic [7:0] OP_ABORT   = 8'hF0;
  localparam logic [7:0] OP_KEY_A   = 8'hAA;
  localparam logic [7:0] OP_KEY_B   = 8'h55;
  localparam logic [7:0] OP_SKIPKEY = 8'h20;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECT    = 8'h30;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic abort;
  } act_s;

endpackage

// File: rtl/fus_match.sv
module fus_match #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 11,
  parameter logic [IDX_W-1:0] UNLOCK0   = 11'h555,
  parameter logic [IDX_W-1:0] UNLOCK1   = 11'h2AA,
  parameter logic [IDX_W-1:0] QUERY_IDX = 11'h055
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        op,
  output logic              at_key0,
  output logic              key0_hit,
  output logic              key1_hit,
  output logic              query_hit,
  output logic              abort_hit
);
  import fus_pkg::*;

  logic [IDX_W-1:0] idx;

  assign idx       = addr[IDX_W-1:0];
  assign op        = data[7:0];
  assign at_key0   = (idx == UNLOCK0);
  assign key0_hit  = at_key0 && (op == OP_KEY_A);
  assign key1_hit  = (idx == UNLOCK1) && (op == OP_KEY_B);
  assign query_hit = (idx == QUERY_IDX) && (op == OP_QUERY);
  assign abort_hit = (op == OP_ABORT);

endmodule

// File: rtl/fus_fsm.sv
module fus_fsm (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             eng_done,
  input  logic [7:0]       op,
  input  logic             at_key0,
  input  logic             key0_hit,
  input  logic             key1_hit,
  input  logic             query_hit,
  input  logic             abort_hit,
  output fus_pkg::cyc_e    cyc,
  output logic [7:0]       mode,
  output logic             byp,
  output fus_pkg::act_s    act
);
  import fus_pkg::*;

  cyc_e       n_cyc;
  logic [7:0] n_mode;
  logic       n_byp;
  logic       go_idle;
  logic       go_cmd;

  always_comb begin
    n_cyc   = cyc;
    n_mode  = mode;
    n_byp   = byp;
    act     = '0;
    go_idle = 1'b0;
    go_cmd  = 1'b0;
    if (eng_done) begin
      n_mode = OP_NONE;
      n_cyc  = byp ? CYC_CMD : CYC_IDLE;
    end else if (wr_en) begin
      if (abort_hit && mode != OP_PROG) begin
        go_idle   = 1'b1;
        act.abort = 1'b1;
      end else begin
        case (cyc)
          CYC_IDLE: begin
            if (query_hit) begin
              n_cyc  = CYC_QUERY;
              n_mode = OP_QUERY;
            end else if (key0_hit) begin
              n_cyc = CYC_KEY2;
            end else begin
              go_idle = 1'b1;
            end
          end
          CYC_KEY2: begin
            if (key1_hit) n_cyc = CYC_CMD;
            else          go_idle = 1'b1;
          end
          CYC_CMD: begin
            if (!byp && !at_key0) begin
              go_idle = 1'b1;
            end else begin
              case (op)
                OP_SKIPKEY: begin
                  n_byp  = 1'b1;
                  go_cmd = 1'b1;
                end
                OP_ERASE, OP_IDENT, OP_PROG: begin
                  n_mode = op;
                  n_cyc  = CYC_ARG;
                end
                default: go_idle = 1'b1;
              endcase
            end
          end
          CYC_ARG: begin
            case (mode)
              OP_ERASE: begin
                if (key0_hit) n_cyc = CYC_ER_KEY2;
                else          go_idle = 1'b1;
              end
              OP_PROG: begin
                act.prog = 1'b1;
                if (byp) go_cmd = 1'b1;
                else     go_idle = 1'b1;
              end
              OP_IDENT: begin
                if (byp && op == OP_NONE) begin
                  go_idle = 1'b1;
                end else if (query_hit) begin
                  n_cyc  = CYC_QUERY;
                  n_mode = OP_QUERY;
                end else begin
                  go_idle = 1'b1;
                end
              end
              default: go_idle = 1'b1;
            endcase
          end
          CYC_ER_KEY2: begin
            if (mode == OP_ERASE && key1_hit) n_cyc = CYC_ER_SEL;
            else                              go_idle = 1'b1;
          end
          CYC_ER_SEL: begin
            if (op == OP_CHIP && at_key0) begin
              act.chip = 1'b1;
              n_mode   = OP_CHIP;
              n_cyc    = CYC_ERASING;
            end else if (op == OP_SECT) begin
              act.sect = 1'b1;
              n_mode   = OP_SECT;
              n_cyc    = CYC_ERASING;
            end else begin
              go_idle = 1'b1;
            end
          end
          CYC_ERASING: begin
            n_cyc = cyc;
          end
          default: go_idle = 1'b1;
        endcase
      end
      if (go_idle) begin
        n_cyc  = CYC_IDLE;
        n_mode = OP_NONE;
        n_byp  = 1'b0;
      end else if (go_cmd) begin
        n_cyc  = CYC_CMD;
        n_mode = OP_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= CYC_IDLE;
      mode <= OP_NONE;
      byp  <= 1'b0;
    end else begin
      cyc  <= n_cyc;
      mode <= n_mode;
      byp  <= n_byp;
    end
  end

endmodule

// File: rtl/fus_req.sv
module fus_req #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SECT_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fus_pkg::act_s     act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        size,
  output fus_pkg::act_s     req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        req_size
);
  import fus_pkg::*;

  localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_BITS) - ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= '0;
      req_addr <= '0;
      req_data <= '0;
      req_size <= '0;
    end else begin
      req <= act;
      if (act.prog) begin
        req_addr <= addr;
        req_data <= data;
        req_size <= size;
      end else if (act.sect) begin
        req_addr <= addr & SECT_MASK;
      end
    end
  end

endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int IDX_W        = 11,
  parameter int SECTOR_WORDS = 2048,
  parameter logic [IDX_W-1:0] UNLOCK0   = 11'h555,
  parameter logic [IDX_W-1:0] UNLOCK1   = 11'h2AA,
  parameter logic [IDX_W-1:0] QUERY_IDX = 11'h055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  input  logic              eng_done,
  output logic [7:0]        mode_code,
  output logic [2:0]        seq_cycle,
  output logic              bypass_on,
  output logic              prog_req,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic              reset_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        req_size
);
  import fus_pkg::*;

  localparam int SECT_BITS = $clog2(SECTOR_WORDS);

  logic [7:0] op;
  logic       at_key0, key0_hit, key1_hit, query_hit, abort_hit;
  cyc_e       cyc;
  act_s       act;
  act_s       req;

  fus_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1), .QUERY_IDX(QUERY_IDX)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .op(op), .at_key0(at_key0),
    .key0_hit(key0_hit), .key1_hit(key1_hit), .query_hit(query_hit),
    .abort_hit(abort_hit)
  );

  fus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .eng_done(eng_done), .op(op),
    .at_key0(at_key0), .key0_hit(key0_hit), .key1_hit(key1_hit),
    .query_hit(query_hit), .abort_hit(abort_hit),
    .cyc(cyc), .mode(mode_code), .byp(bypass_on), .act(act)
  );

  fus_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_req (
    .clk(clk), .rst_n(rst_n), .act(act), .addr(wr_addr), .data(wr_data),
    .size(wr_size), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_size(req_size)
  );

  assign seq_cycle        = cyc;
  assign prog_req         = req.prog;
  assign chip_erase_req   = req.chip;
  assign sector_erase_req = req.sect;
  assign reset_req        = req.abort;

endmodule

// File: rtl/fus_checker.sv
module fus_checker #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int SECTOR_WORDS = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              eng_done,
  input logic [7:0]        mode_code,
  input logic [2:0]        seq_cycle,
  input logic              bypass_on,
  input logic              prog_req,
  input logic              chip_erase_req,
  input logic              sector_erase_req,
  input logic              reset_req,
  input logic [ADDR_W-1:0] req_addr
);
  localparam int SB = $clog2(SECTOR_WORDS);

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sector_erase_req, reset_req}));

  // R5
  prog_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(seq_cycle) == 3'd3 && $past(mode_code) == 8'hA0));

  // R7
  chip_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |-> (seq_cycle == 3'd6 && mode_code == 8'h10));

  // R7
  sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_req |-> (req_addr[SB-1:0] == '0 && mode_code == 8'h30));

  // R11
  done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (mode_code == 8'h00 &&
                  ((bypass_on && seq_cycle == 3'd2) || (!bypass_on && seq_cycle == 3'd0))));

  // R2
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !eng_done && wr_data[7:0] == 8'hF0 && mode_code != 8'hA0)
      |=> (seq_cycle == 3'd0 && mode_code == 8'h00 && !bypass_on && reset_req));

  // R9
  query_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_cycle == 3'd7) |-> (mode_code == 8'h98));

  // R8
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_cycle == 3'd6 && wr_en && !eng_done && wr_data[7:0] != 8'hF0)
      |=> (seq_cycle == 3'd6 && $stable(mode_code) && $stable(bypass_on)));

endmodule

bind flash_unlock_seq fus_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_WORDS(SECTOR_WORDS)
) u_fus_checker (.*);

// File: tb/flash_unlock_seq_bench.sv
module flash_unlock_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    wr_size = '0;
  logic          eng_done = 1'b0;
  logic [7:0]    mode_code;
  logic [2:0]    seq_cycle;
  logic          bypass_on;
  logic          prog_req, chip_erase_req, sector_erase_req, reset_req;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [1:0]    req_size;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0] cap_req;

  flash_unlock_seq #(
    .ADDR_W(AW), .DATA_W(DW), .IDX_W(11), .SECTOR_WORDS(256),
    .UNLOCK0(11'h555), .UNLOCK1(11'h2AA), .QUERY_IDX(11'h055)
  ) u_flash_unlock_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size), .eng_done(eng_done),
    .mode_code(mode_code), .seq_cycle(seq_cycle), .bypass_on(bypass_on),
    .prog_req(prog_req), .chip_erase_req(chip_erase_req),
    .sector_erase_req(sector_erase_req), .reset_req(reset_req),
    .req_addr(req_addr), .req_data(req_data), .req_size(req_size)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // state check: cycle, mode, bypass
  task automatic check_state(input string tag, input logic [2:0] c, input logic [7:0] m,
                             input logic b);
    check({tag, " cycle"}, 32'(seq_cycle), 32'(c));
    check({tag, " mode"}, 32'(mode_code), 32'(m));
    check({tag, " bypass"}, 32'(bypass_on), 32'(b));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    eng_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one write; outputs captured one edge later
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s = 2'd1);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    wr_size = s;
    @(negedge clk);
    wr_en   = 1'b0;
    cap_req = {prog_req, chip_erase_req, sector_erase_req, reset_req};
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic t_reset_state();
    do_reset();
    check_state("R1 after reset", 3'd0, 8'h00, 1'b0);
    check("R1 no requests", 32'({prog_req, chip_erase_req, sector_erase_req, reset_req}), 32'h0);
  endtask

  task automatic t_program();
    do_reset();
    unlock();
    check_state("R3 key pair done", 3'd2, 8'h00, 1'b0);
    wr(16'h0555, 16'h00A0);
    check_state("R4 program armed", 3'd3, 8'hA0, 1'b0);
    wr(16'h4321, 16'h1234, 2'd2);
    check("R5 prog pulse", 32'(cap_req), 32'h8);
    check("R5 prog addr", 32'(req_addr), 32'h4321);
    check("R5 prog data", 32'(req_data), 32'h1234);
    check("R5 prog size", 32'(req_size), 32'd2);
    check_state("R5 back to read", 3'd0, 8'h00, 1'b0);
    @(negedge clk);
    check("R12 prog one cycle", 32'(prog_req), 32'h0);
  endtask

  task automatic t_bad_keys();
    do_reset();
    wr(16'h0555, 16'h00AA);
    check_state("R3 first key", 3'd1, 8'h00, 1'b0);
    wr(16'h0123, 16'h0055);
    check_state("R3 second key wrong index", 3'd0, 8'h00, 1'b0);
    wr(16'h0100, 16'h00AA);
    check_state("R3 first key wrong index", 3'd0, 8'h00, 1'b0);
    // index matches low 11 bits only; upper bits ignored
    wr(16'h0D55, 16'h00AA);
    check_state("R3 high address bits ignored", 3'd1, 8'h00, 1'b0);
  endtask

  task automatic t_bad_command();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0077);
    check_state("R4 unknown command", 3'd0, 8'h00, 1'b0);
    unlock();
    wr(16'h0444, 16'h00A0);
    check_state("R4 command at wrong index", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic t_bypass();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0020);
    check_state("R6 bypass armed", 3'd2, 8'h00, 1'b1);
    wr(16'h0077, 16'h00A0);
    check_state("R6 command any index", 3'd3, 8'hA0, 1'b1);
    wr(16'h0010, 16'hBEEF);
    check("R6 prog pulse", 32'(cap_req), 32'h8);
    check_state("R6 back to cycle 2", 3'd2, 8'h00, 1'b1);
    wr(16'h0077, 16'h0090);
    check_state("R10 ident in bypass", 3'd3, 8'h90, 1'b1);
    wr(16'h0000, 16'h0000);
    check_state("R10 bypass exit", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic t_ident_query();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0090);
    check_state("R4 ident armed", 3'd3, 8'h90, 1'b0);
    wr(16'h0055, 16'h0098);
    check_state("R9 query from ident", 3'd7, 8'h98, 1'b0);
    wr(16'h0003, 16'h00F0);
    check("R2 abort pulse in query", 32'(cap_req), 32'h1);
    check_state("R2 abort to read", 3'd0, 8'h00, 1'b0);
    unlock();
    wr(16'h0555, 16'h0090);
    wr(16'h0003, 16'h0012);
    check_state("R10 other write resets", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic t_query_direct();
    do_reset();
    wr(16'h0055, 16'h0098);
    check_state("R9 direct query", 3'd7, 8'h98, 1'b0);
    wr(16'h0055, 16'h0098);
    check_state("R9 write in query resets", 3'd0, 8'h00, 1'b0);
    check("R9 no abort pulse", 32'(cap_req), 32'h0);
  endtask

  task automatic t_chip_erase();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0080);
    unlock();
    check_state("R7 second key pair", 3'd5, 8'h80, 1'b0);
    wr(16'h0555, 16'h0010);
    check("R7 chip pulse", 32'(cap_req), 32'h4);
    check_state("R7 chip erasing", 3'd6, 8'h10, 1'b0);
    wr(16'h0555, 16'h00AA);
    check("R8 ignored no request", 32'(cap_req), 32'h0);
    check_state("R8 erase holds", 3'd6, 8'h10, 1'b0);
    pulse_done();
    check_state("R11 done to read", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic t_chip_wrong_index();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0080);
    unlock();
    wr(16'h0100, 16'h0010);
    check("R7 chip wrong index no pulse", 32'(cap_req), 32'h0);
    check_state("R7 chip wrong index resets", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic t_sector_bypass();
    do_reset();
    unlock();
    wr(16'h0555, 16'h0020);
    wr(16'h0123, 16'h0080);
    check_state("R6 erase in bypass", 3'd3, 8'h80, 1'b1);
    unlock();
    wr(16'h1234, 16'h0030);
    check("R7 sector pulse", 32'(cap_req), 32'h2);
    check("R7 sector aligned", 32'(req_addr), 32'h1200);
    check_state("R7 sector erasing", 3'd6, 8'h30, 1'b1);
    pulse_done();
    check_state("R11 done to cycle 2", 3'd2, 8'h00, 1'b1);
  endtask

  task automatic t_abort_in_program();
    do_reset();
    unlock();
    wr(16'h0555, 16'h00A0);
    wr(16'h0200, 16'h00F0);
    check("R2 F0 programs when armed", 32'(cap_req), 32'h8);
    check("R2 F0 program data", 32'(req_data), 32'h00F0);
    unlock();
    wr(16'h0555, 16'h0080);
    wr(16'h0000, 16'h00F0);
    check("R2 abort pulse", 32'(cap_req), 32'h1);
    check_state("R2 abort resets", 3'd0, 8'h00, 1'b0);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset_state();
    t_program();
    t_bad_keys();
    t_bad_command();
    t_bypass();
    t_ident_query();
    t_query_direct();
    t_chip_erase();
    t_chip_wrong_index();
    t_sector_bypass();
    t_abort_in_program();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule